// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two byte-wide buses, side A and side B, in both directions. The 16 bits are split into two byte halves, and each half is controlled on its own. Each half has two paths, one from A to B and one from B to A. Every path has its own byte of storage and three active-low controls: a chip select, a latch open and a drive enable. While the chip select and the latch open are both low, the storage is transparent. Raising the latch open freezes the last accepted byte. The drive enable decides whether the far side is driven, either with the live byte or with the frozen one.

The tri-state pins are split into synthesizable pieces. Each side has an input vector and an output vector, plus one active-high drive flag per half, so an outer pad ring can build the real bidirectional pins. The data path is a pure pass-through with no storage queue. It therefore has no valid/ready handshake and can never apply back-pressure: a byte offered while a path is closed is simply not taken. The storage is a clocked register that loads on each rising clock edge while the path is open. The outputs pick the live input while the path is open, so the far side follows the input in the same cycle.

Top module: `latched_xcvr`

## Requirements
- R1: An active-low reset clears every stored byte to 0x00. After reset, a path that drives while its latch open is high presents 0x00.
- R2: With chip select, latch open and drive enable all low, the far-side output of that half equals the live input of that half in the same cycle.
- R3: With chip select low and latch open high, the path presents the byte present at the last clock edge at which chip select and latch open were both low. Later input changes do not alter it.
- R4: With chip select high, the path's drive flag is 0 and its stored byte is not loaded, whatever the latch open and drive enable levels are.
- R5: With drive enable high, the drive flag is 0, but the storage still loads while chip select and latch open are low.
- R6: While a half's drive flag is 0, that half's output byte is 0x00.
- R7: The two halves are independent. Half 0 is bits 7:0 with control bit 0, and half 1 is bits 15:8 with control bit 1. One half may be transparent while the other holds.
- R8: The B-to-A path follows R2 to R6 with its own three controls and the roles of the two sides swapped. It never affects the A-to-B storage.
- R9: A drive flag is 1 exactly when that half's chip select and drive enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Bytes arriving on side A |
| a_out | output | 16 | Bytes driven onto side A by the B-to-A paths |
| a_drv | output | 2 | Per-half drive flag for side A |
| b_in | input | 16 | Bytes arriving on side B |
| b_out | output | 16 | Bytes driven onto side B by the A-to-B paths |
| b_drv | output | 2 | Per-half drive flag for side B |
| ab_sel_n | input | 2 | Per-half active-low chip select, A-to-B |
| ab_open_n | input | 2 | Per-half active-low latch open, A-to-B |
| ab_drive_n | input | 2 | Per-half active-low drive enable, A-to-B |
| ba_sel_n | input | 2 | Per-half active-low chip select, B-to-A |
| ba_open_n | input | 2 | Per-half active-low latch open, B-to-A |
| ba_drive_n | input | 2 | Per-half active-low drive enable, B-to-A |

## Verification
The hardest state to reach from the ports is a stored byte that differs from the live input while the output is still visible. Reaching it takes a load with the drive enable off, then a freeze, then switching on the drive with new data at the input. The stimulus table walks this order step by step on one path, together with loads that are blocked by a high chip select. Directed steps then freeze one half while the other stays transparent, so a leak between halves shows up as a wrong byte in one half.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XC_HALVES = 2;
  localparam int XC_LANE   = 8;

  // one set of active-low controls for a single direction of a single half
  typedef struct packed {
    logic sel_n;
    logic open_n;
    logic drive_n;
  } xc_ctrl_t;
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int LANE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LANE-1:0] din,
  input  xcvr_pkg::xc_ctrl_t ctl,
  output logic [LANE-1:0] dout,
  output logic            drive
);
  logic [LANE-1:0] held;
  logic            open_now;

  assign open_now = !ctl.sel_n && !ctl.open_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= '0;
    else if (open_now) held <= din;
  end

  assign drive = !ctl.sel_n && !ctl.drive_n;
  assign dout  = drive ? (open_now ? din : held) : '0;
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int LANE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANE-1:0]    a_in,
  input  logic [LANE-1:0]    b_in,
  input  xcvr_pkg::xc_ctrl_t ab_ctl,
  input  xcvr_pkg::xc_ctrl_t ba_ctl,
  output logic [LANE-1:0]    a_out,
  output logic               a_drv,
  output logic [LANE-1:0]    b_out,
  output logic               b_drv
);
  xcvr_path #(.LANE(LANE)) u_ab (
    .clk(clk), .rst_n(rst_n), .din(a_in), .ctl(ab_ctl),
    .dout(b_out), .drive(b_drv)
  );

  xcvr_path #(.LANE(LANE)) u_ba (
    .clk(clk), .rst_n(rst_n), .din(b_in), .ctl(ba_ctl),
    .dout(a_out), .drive(a_drv)
  );
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
  parameter int HALVES = xcvr_pkg::XC_HALVES,
  parameter int LANE   = xcvr_pkg::XC_LANE,
  localparam int WIDTH = HALVES * LANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  a_in,
  output logic [WIDTH-1:0]  a_out,
  output logic [HALVES-1:0] a_drv,
  input  logic [WIDTH-1:0]  b_in,
  output logic [WIDTH-1:0]  b_out,
  output logic [HALVES-1:0] b_drv,
  input  logic [HALVES-1:0] ab_sel_n,
  input  logic [HALVES-1:0] ab_open_n,
  input  logic [HALVES-1:0] ab_drive_n,
  input  logic [HALVES-1:0] ba_sel_n,
  input  logic [HALVES-1:0] ba_open_n,
  input  logic [HALVES-1:0] ba_drive_n
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_pkg::xc_ctrl_t ab_c, ba_c;
    assign ab_c = '{sel_n: ab_sel_n[h], open_n: ab_open_n[h], drive_n: ab_drive_n[h]};
    assign ba_c = '{sel_n: ba_sel_n[h], open_n: ba_open_n[h], drive_n: ba_drive_n[h]};

    xcvr_half #(.LANE(LANE)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .a_in  (a_in[h*LANE +: LANE]),
      .b_in  (b_in[h*LANE +: LANE]),
      .ab_ctl(ab_c),
      .ba_ctl(ba_c),
      .a_out (a_out[h*LANE +: LANE]),
      .a_drv (a_drv[h]),
      .b_out (b_out[h*LANE +: LANE]),
      .b_drv (b_drv[h])
    );
  end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int HALVES = 2,
  parameter int LANE   = 8,
  localparam int WIDTH = HALVES * LANE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIDTH-1:0]  a_in,
  input logic [WIDTH-1:0]  a_out,
  input logic [HALVES-1:0] a_drv,
  input logic [WIDTH-1:0]  b_in,
  input logic [WIDTH-1:0]  b_out,
  input logic [HALVES-1:0] b_drv,
  input logic [HALVES-1:0] ab_sel_n,
  input logic [HALVES-1:0] ab_open_n,
  input logic [HALVES-1:0] ab_drive_n,
  input logic [HALVES-1:0] ba_sel_n,
  input logic [HALVES-1:0] ba_open_n,
  input logic [HALVES-1:0] ba_drive_n
);
  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    a_r2_ab_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_sel_n[h] && !ab_open_n[h] && !ab_drive_n[h]) |-> b_out[h*LANE +: LANE] == a_in[h*LANE +: LANE]);

    a_r3_ab_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ab_sel_n[h] && ab_open_n[h] && !ab_drive_n[h] &&
       $past(!ab_sel_n[h] && ab_open_n[h] && !ab_drive_n[h])) |-> $stable(b_out[h*LANE +: LANE]));

    a_r4_ab_sel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ab_sel_n[h] |-> !b_drv[h]);

    a_r5_ab_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
      ab_drive_n[h] |-> !b_drv[h]);

    a_r6_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drv[h] |-> b_out[h*LANE +: LANE] == '0);

    a_r6_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drv[h] |-> a_out[h*LANE +: LANE] == '0);

    a_r8_ba_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_sel_n[h] && !ba_open_n[h] && !ba_drive_n[h]) |-> a_out[h*LANE +: LANE] == b_in[h*LANE +: LANE]);

    a_r9_ab_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_sel_n[h] && !ab_drive_n[h]) |-> b_drv[h]);

    a_r9_ba_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_sel_n[h] && !ba_drive_n[h]) |-> a_drv[h]);
  end
endmodule

bind latched_xcvr xcvr_checker #(.HALVES(HALVES), .LANE(LANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
  .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
  .ab_sel_n(ab_sel_n), .ab_open_n(ab_open_n), .ab_drive_n(ab_drive_n),
  .ba_sel_n(ba_sel_n), .ba_open_n(ba_open_n), .ba_drive_n(ba_drive_n)
);

// File: tb/tb_latched_xcvr.sv
module tb_latched_xcvr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_drv, b_drv;
  logic [1:0]  ab_sel_n = '1, ab_open_n = '1, ab_drive_n = '1;
  logic [1:0]  ba_sel_n = '1, ba_open_n = '1, ba_drive_n = '1;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  latched_xcvr dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_sel_n(ab_sel_n), .ab_open_n(ab_open_n), .ab_drive_n(ab_drive_n),
    .ba_sel_n(ba_sel_n), .ba_open_n(ba_open_n), .ba_drive_n(ba_drive_n)
  );

  // {sel_n, open_n, drive_n, a byte, expected flag, expected b byte} on half 0, A-to-B
  localparam logic [19:0] TBL [0:11] = '{
    {1'b1, 1'b0, 1'b0, 8'hAA, 1'b0, 8'h00},  // R4 select high: no load, no drive
    {1'b0, 1'b1, 1'b0, 8'h11, 1'b1, 8'h00},  // R1 stored zero shown
    {1'b0, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h5A},  // R2 transparent
    {1'b0, 1'b1, 1'b0, 8'hC3, 1'b1, 8'h5A},  // R3 hold
    {1'b0, 1'b1, 1'b1, 8'hC3, 1'b0, 8'h00},  // R5 drive off
    {1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 8'h00},  // R5 loads while not driving
    {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h77},  // R5 loaded byte appears
    {1'b1, 1'b0, 1'b0, 8'h99, 1'b0, 8'h00},  // R4 blocked load
    {1'b0, 1'b1, 1'b0, 8'h99, 1'b1, 8'h77},  // R4 store untouched
    {1'b1, 1'b1, 1'b1, 8'h12, 1'b0, 8'h00},  // R6 idle output zero
    {1'b0, 1'b0, 1'b0, 8'hF0, 1'b1, 8'hF0},  // R2 transparent again
    {1'b0, 1'b1, 1'b0, 8'h0F, 1'b1, 8'hF0}   // R3 hold new byte
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    #1;
    check("R6 reset b_drv", {14'd0, b_drv}, 16'h0);
    check("R6 reset b_out", b_out, 16'h0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    ab_sel_n = 2'b00; ab_open_n = 2'b11; ab_drive_n = 2'b00;
    ba_sel_n = 2'b00; ba_open_n = 2'b11; ba_drive_n = 2'b00;
    step();
    check("R1 b_out after reset", b_out, 16'h0);
    check("R1 a_out after reset", a_out, 16'h0);
    check("R9 both flags", {12'd0, a_drv, b_drv}, 16'h000F);

    // table walk on half 0, half 1 idle
    @(negedge clk);
    ab_sel_n = 2'b11; ab_open_n = 2'b11; ab_drive_n = 2'b11;
    ba_sel_n = 2'b11; ba_open_n = 2'b11; ba_drive_n = 2'b11;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ab_sel_n[0]   = TBL[i][19];
      ab_open_n[0]  = TBL[i][18];
      ab_drive_n[0] = TBL[i][17];
      a_in[7:0]     = TBL[i][16:9];
      step();
      check($sformatf("R9 row %0d flag", i), {15'd0, b_drv[0]}, {15'd0, TBL[i][8]});
      check($sformatf("R2/R3 row %0d data", i), b_out, {8'h00, TBL[i][7:0]});
    end

    // R8: B-to-A on half 1
    @(negedge clk);
    ab_sel_n = 2'b11;
    ba_sel_n[1] = 1'b0; ba_open_n[1] = 1'b0; ba_drive_n[1] = 1'b0;
    b_in[15:8] = 8'h3C;
    #1;
    check("R8 B-to-A transparent same cycle", a_out, 16'h3C00);
    step();
    @(negedge clk);
    ba_open_n[1] = 1'b1; b_in[15:8] = 8'hFF;
    step();
    check("R8 B-to-A hold", a_out, 16'h3C00);
    check("R4 A-to-B idle while B-to-A drives", {14'd0, b_drv}, 16'h0);
    check("R8 flags", {12'd0, a_drv, b_drv}, 16'h0008);

    // R8: A-to-B half 0 store not touched by B-to-A traffic
    @(negedge clk);
    ab_sel_n[0] = 1'b0; ab_open_n[0] = 1'b1; ab_drive_n[0] = 1'b0;
    step();
    check("R8 A-to-B store intact", b_out, 16'h00F0);

    // R7: half 0 transparent while half 1 holds
    @(negedge clk);
    ab_sel_n = 2'b00; ab_open_n = 2'b00; ab_drive_n = 2'b00;
    a_in = 16'h8142;
    step();
    check("R7 both transparent", b_out, 16'h8142);
    @(negedge clk);
    ab_open_n = 2'b10; a_in = 16'hE724;
    step();
    check("R7 half0 live, half1 held", b_out, 16'h8124);
    @(negedge clk);
    ab_open_n = 2'b01; a_in = 16'h5566;
    step();
    check("R7 half0 held, half1 live", b_out, 16'h5524);

    // R1: reset mid-run clears stores
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ab_open_n = 2'b11; ba_open_n = 2'b11;
    ba_sel_n = 2'b00; ba_drive_n = 2'b00;
    step();
    check("R1 A-to-B cleared", b_out, 16'h0);
    check("R1 B-to-A cleared", a_out, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule